// File: doc/BRIEF.md
# Indexed Codec Control Register Block

This block holds the control state of an audio codec behind a 64-byte window of sixteen 32-bit words. A host selects a word with a byte address, writes it with a single-cycle strobe and sees read data for the addressed word in the same cycle. Word 0 is a pointer: its low five bits pick one of thirty-two 8-bit indirect slots. Word 1 is a window onto whichever slot the pointer names. Every other word is a plain storage word, except word 2, which ignores writes, and word 4, which keeps only seven bits.

Some indirect slots have access rules. One slot reads as zero. Two slots ignore writes. One slot mixes a single writable bit with a fixed codec version code. Setting bit 0 of word 4 resets both banks. A synchronous hardware reset input performs the same clear and reload. The bus has no handshake and no back-pressure. A write completes at the clock edge where `wr_en` is high. A read is a pure function of `addr` and the current state.

Top module: `codec_regfile`

## Requirements
- R1: After reset every direct word reads 0. Indirect slot 12 reads 0x8A, slot 25 reads 0xA0, and every other slot reads 0.
- R2: Words 0, 3 and 5 to 15 store all 32 bits of a write and read them back unchanged.
- R3: A read of word 1 (byte address 0x04) returns the indirect slot chosen by bits 4:0 of word 0, zero-extended to 32 bits. Bits 31:5 of word 0 do not affect the selection.
- R4: A write to word 1 stores bits 7:0 of the write data into the selected slot. Slots 3, 11, 12 and 25 are excepted.
- R5: A read of word 1 while slot 3 is selected returns 0, even after a non-zero write to that slot.
- R6: Writes to slots 11 and 25 leave their contents unchanged.
- R7: A write to slot 12 stores (data AND 0x40) OR 0x8A.
- R8: Writes to word 2 are ignored, so word 2 keeps reading 0.
- R9: A write to word 4 stores the data AND 0x7F.
- R10: A write to word 4 with bit 0 set clears every other direct word and reloads the indirect bank as in R1. In the same edge, word 4 takes the masked value from R9.
- R11: While `rst` is high at a clock edge, the block applies the R1 state and ignores any write made in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Byte address; bits 5:2 select the word |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the addressed word, combinational |

## Verification
On every cycle, the assertions check the following:
- word 2 stays at zero;
- word 4 holds the masked value after any write to it;
- a software reset zeroes the pointer;
- slot 25 keeps its chip code and slot 12 keeps its version field;
- slots 11 and 25 are unchanged after port writes;
- an ordinary slot captures its byte.

Only the bench scenarios can show the remaining behaviours:
- the read value seen at the port, including the zero returned for slot 3;
- that pointer bits above bit 4 are ignored;
- that a software or hardware reset also wipes the storage words and data written earlier.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;
  localparam int WIN_BYTES  = 64;
  localparam int WORD_BYTES = 4;
  localparam int N_WORDS    = WIN_BYTES / WORD_BYTES;
  localparam int WORD_W     = 32;
  localparam int N_SLOTS    = 32;
  localparam int SLOT_W     = 8;
  localparam int WSEL_W     = $clog2(N_WORDS);
  localparam int BOFF_W     = $clog2(WORD_BYTES);
  localparam int ADDR_W     = WSEL_W + BOFF_W;
  localparam int IDX_W      = $clog2(N_SLOTS);

  // direct word roles
  localparam int WD_PTR  = 0;
  localparam int WD_PORT = 1;
  localparam int WD_LOCK = 2;
  localparam int WD_CTRL = 4;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h0000_007F;

  // indirect slot roles
  localparam int SL_HIDDEN  = 3;
  localparam int SL_FIXED_A = 11;
  localparam int SL_VER     = 12;
  localparam int SL_FIXED_B = 25;
  localparam logic [SLOT_W-1:0] CODEC_CODE = 8'h8A;
  localparam logic [SLOT_W-1:0] CHIP_CODE  = 8'hA0;
  localparam logic [SLOT_W-1:0] VER_OPEN   = 8'h40;

  function automatic logic [SLOT_W-1:0] slot_init(input int s);
    if (s == SL_VER)          return CODEC_CODE;
    else if (s == SL_FIXED_B) return CHIP_CODE;
    else                      return '0;
  endfunction
endpackage

// File: rtl/codec_direct_bank.sv
module codec_direct_bank
  import codec_regs_pkg::*;
#(
  parameter int NW = N_WORDS,
  parameter int DW = WORD_W,
  localparam int SW = $clog2(NW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 soft_rst,
  input  logic                 we,
  input  logic [SW-1:0]        sel,
  input  logic [DW-1:0]        wdata,
  output logic [NW-1:0][DW-1:0] words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    localparam bit IS_CTRL  = (g == WD_CTRL);
    localparam bit WRITABLE = (g != WD_PORT) && (g != WD_LOCK);
    logic hit;
    assign hit = we && (sel == SW'(g));
    if (IS_CTRL) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (rst)      words[g] <= '0;
        else if (hit) words[g] <= wdata & DW'(CTRL_KEEP);
      end
    end else if (WRITABLE) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || soft_rst) words[g] <= '0;
        else if (hit)        words[g] <= wdata;
      end
    end else begin : g_held
      always_ff @(posedge clk) begin
        if (rst || soft_rst) words[g] <= '0;
      end
    end
  end

  // R8
  lock_word_zero_chk: assert property (@(posedge clk) disable iff (rst)
    words[WD_LOCK] == '0);
  // R9
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SW'(WD_CTRL)) |=> words[WD_CTRL] == ($past(wdata) & DW'(CTRL_KEEP)));
  // R10
  soft_ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> words[WD_PTR] == '0);
endmodule

// File: rtl/codec_slot_bank.sv
module codec_slot_bank
  import codec_regs_pkg::*;
#(
  parameter int NS = N_SLOTS,
  parameter int SW = SLOT_W,
  localparam int IW = $clog2(NS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  we,
  input  logic [IW-1:0]         idx,
  input  logic [SW-1:0]         wdata,
  output logic [NS-1:0][SW-1:0] slots
);
  for (genvar g = 0; g < NS; g++) begin : g_slot
    localparam bit FIXED = (g == SL_FIXED_A) || (g == SL_FIXED_B);
    localparam bit VER   = (g == SL_VER);
    localparam logic [SW-1:0] INIT = SW'(slot_init(g));
    logic hit;
    assign hit = we && (idx == IW'(g));
    if (FIXED) begin : g_fixed
      always_ff @(posedge clk) begin
        if (clr) slots[g] <= INIT;
      end
    end else if (VER) begin : g_ver
      always_ff @(posedge clk) begin
        if (clr)      slots[g] <= INIT;
        else if (hit) slots[g] <= (wdata & SW'(VER_OPEN)) | SW'(CODEC_CODE);
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (clr)      slots[g] <= INIT;
        else if (hit) slots[g] <= wdata;
      end
    end
  end

  // R1
  chip_code_chk: assert property (@(posedge clk) disable iff (rst)
    slots[SL_FIXED_B] == SW'(CHIP_CODE));
  // R7
  ver_field_chk: assert property (@(posedge clk) disable iff (rst)
    (slots[SL_VER] & ~SW'(VER_OPEN)) == SW'(CODEC_CODE));
  // R6
  fixed_slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !clr) |=> (slots[SL_FIXED_A] == $past(slots[SL_FIXED_A])) &&
                     (slots[SL_FIXED_B] == $past(slots[SL_FIXED_B])));
  // R4
  plain_store_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !clr && idx != IW'(SL_FIXED_A) && idx != IW'(SL_FIXED_B) &&
     idx != IW'(SL_VER)) |=> slots[$past(idx)] == $past(wdata));
endmodule

// File: rtl/codec_regfile.sv
module codec_regfile
  import codec_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  logic [WSEL_W-1:0]               wsel;
  logic [IDX_W-1:0]                ptr;
  logic                            port_we;
  logic                            soft_rst;
  logic                            slot_clr;
  logic [N_WORDS-1:0][WORD_W-1:0]  words;
  logic [N_SLOTS-1:0][SLOT_W-1:0]  slots;
  logic                            unused_bits;

  assign wsel     = addr[ADDR_W-1:BOFF_W];
  assign ptr      = words[WD_PTR][IDX_W-1:0];
  assign port_we  = wr_en && !rst && (wsel == WSEL_W'(WD_PORT));
  assign soft_rst = wr_en && !rst && (wsel == WSEL_W'(WD_CTRL)) && wr_data[0];
  assign slot_clr = rst || soft_rst;
  assign unused_bits = ^{addr[BOFF_W-1:0], words[WD_PTR][WORD_W-1:IDX_W], words[WD_PORT]};

  codec_direct_bank #(.NW(N_WORDS), .DW(WORD_W)) u_direct (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .we(wr_en),
    .sel(wsel), .wdata(wr_data), .words(words)
  );

  codec_slot_bank #(.NS(N_SLOTS), .SW(SLOT_W)) u_slots (
    .clk(clk), .rst(rst), .clr(slot_clr), .we(port_we),
    .idx(ptr), .wdata(wr_data[SLOT_W-1:0]), .slots(slots)
  );

  always_comb begin
    if (wsel == WSEL_W'(WD_PORT)) begin
      if (ptr == IDX_W'(SL_HIDDEN)) rd_data = '0;
      else                          rd_data = WORD_W'(slots[ptr]);
    end else begin
      rd_data = words[wsel];
    end
  end

  // R11
  hw_reset_ptr_chk: assert property (@(posedge clk)
    rst |=> words[WD_PTR] == '0 && slots[SL_VER] == CODEC_CODE);
endmodule

// File: tb/codec_regfile_bench.sv
module codec_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [5:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  codec_regfile u_codec_regfile (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  // monitor: pops one expected read per falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.tag, it.a, rd_data, it.exp);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a; wr_en = 1'b0;
    it.a = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic slot_rd(input int s, input logic [31:0] e, input string tag);
    wr(6'h00, 32'(s));
    rd(6'h04, e, tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int w = 0; w < 16; w++) rd(6'(w * 4), (w == 1) ? 32'h0 : 32'h0, "R1 word");
    slot_rd(12, 32'h8A, "R1 slot12");
    slot_rd(25, 32'hA0, "R1 slot25");
    slot_rd(31, 32'h0,  "R1 slot31");

    // R2 storage words
    wr(6'h14, 32'hDEADBEEF);
    wr(6'h3C, 32'h12345678);
    wr(6'h0C, 32'hA5A5_5A5A);
    rd(6'h14, 32'hDEADBEEF, "R2 word5");
    rd(6'h3C, 32'h12345678, "R2 word15");
    rd(6'h0C, 32'hA5A5_5A5A, "R2 word3");
    wr(6'h00, 32'hFFFF_FFE7);
    rd(6'h00, 32'hFFFF_FFE7, "R2 word0");

    // R4 store low byte, R3 read with upper pointer bits set
    wr(6'h04, 32'h0000_01A5);
    rd(6'h04, 32'h0000_00A5, "R3 R4 slot7 via wide ptr");
    wr(6'h00, 32'h0000_0027);
    rd(6'h04, 32'h0000_00A5, "R3 ptr upper bits ignored");
    slot_rd(8, 32'h0, "R3 neighbour slot untouched");

    // R5 hidden slot
    wr(6'h00, 32'h3);
    wr(6'h04, 32'h55);
    rd(6'h04, 32'h0, "R5 slot3 reads zero");

    // R6 fixed slots
    wr(6'h00, 32'd11);
    wr(6'h04, 32'h77);
    rd(6'h04, 32'h0, "R6 slot11 unchanged");
    wr(6'h00, 32'd25);
    wr(6'h04, 32'h11);
    rd(6'h04, 32'hA0, "R6 slot25 unchanged");

    // R7 version slot
    wr(6'h00, 32'd12);
    wr(6'h04, 32'hFF);
    rd(6'h04, 32'hCA, "R7 slot12 with open bit");
    wr(6'h04, 32'h00);
    rd(6'h04, 32'h8A, "R7 slot12 open bit clear");
    wr(6'h04, 32'h40);

    // R8 locked word
    wr(6'h08, 32'hFFFF_FFFF);
    rd(6'h08, 32'h0, "R8 word2 ignores write");

    // R9 control mask without reset
    wr(6'h10, 32'hFFFF_FFFE);
    rd(6'h10, 32'h7E, "R9 word4 masked");
    rd(6'h14, 32'hDEADBEEF, "R9 no clear when bit0 low");

    // R10 software reset
    wr(6'h10, 32'h0000_0081);
    rd(6'h10, 32'h01, "R10 word4 keeps masked value");
    rd(6'h14, 32'h0, "R10 word5 cleared");
    rd(6'h3C, 32'h0, "R10 word15 cleared");
    rd(6'h00, 32'h0, "R10 pointer cleared");
    rd(6'h04, 32'h0, "R10 slot0 cleared");
    slot_rd(7,  32'h0,  "R10 slot7 cleared");
    slot_rd(12, 32'h8A, "R10 slot12 reloaded");
    slot_rd(25, 32'hA0, "R10 slot25 reloaded");

    // R11 hardware reset overrides a write in the same cycle
    wr(6'h18, 32'h5);
    wr(6'h00, 32'd7);
    wr(6'h04, 32'h33);
    rd(6'h04, 32'h33, "R11 setup slot7");
    @(posedge clk); #1;
    rst = 1'b1; wr_en = 1'b1; addr = 6'h14; wr_data = 32'hCAFE_F00D;
    @(posedge clk); #1;
    rst = 1'b0; wr_en = 1'b0;
    rd(6'h14, 32'h0, "R11 write during reset ignored");
    rd(6'h18, 32'h0, "R11 word6 cleared");
    rd(6'h10, 32'h0, "R11 word4 cleared");
    slot_rd(7,  32'h0,  "R11 slot7 cleared");
    slot_rd(12, 32'h8A, "R11 slot12 reloaded");
    slot_rd(25, 32'hA0, "R11 slot25 reloaded");

    @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_run();
  end
endmodule